// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block sits in front of a peripheral's register file and decides which bus writes may reach it. Protected locations (the time-keeping words, control, interrupt enable and oscillator setup) accept a write only while the gate is open. To open the gate, software writes one 32-bit key to the first kick location and then writes a second, different 32-bit key to the second kick location. Any kick write that carries a value other than the expected key closes the gate at once. Writing zero is the usual way to do this.

The gate also holds a small bank of 32-bit scratch words that the same lock protects. The bus is a plain address, write data and write strobe interface with combinational read data. Downstream registers receive one qualified write enable and decode the address themselves. The status location is not protected, because its bits are cleared by writing ones to them and software must be able to do that at any time. Reads are never blocked, and the kick locations always read as zero so that the keys cannot be read back.

Top module: `wp_gate`

## Requirements
- R1: After reset the gate is closed and every scratch word reads 0x00000000.
- R2: The gate opens on the clock edge of a write of 0x95A4F1E0 to offset 0x70. This applies only when the most recent kick write before it was 0x83E70B13 to offset 0x6C, or when the gate is already open. From the next cycle on, protected writes pass.
- R3: A write of the second key to offset 0x70 that has no first key before it leaves the gate closed. A first key on its own does not open the gate.
- R4: A write to offset 0x6C of any value other than 0x83E70B13 closes the gate on that clock edge. The same holds for a write to offset 0x70 of any value other than 0x95A4F1E0, zero included.
- R5: While the gate is closed, writes to the protected offsets do not raise dn_we, and writes to the scratch offsets do not change the stored word.
- R6: While the gate is open, a write to a protected offset raises dn_we in the same cycle. The protected offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x40, 0x48 and 0x54. A write to a scratch offset (0x60, 0x64 or 0x68) stores its data.
- R7: A write to the status offset 0x44 raises dn_we whether or not the gate is open.
- R8: A write to any other offset, including the kick offsets, never raises dn_we.
- R9: Reads are never blocked. A scratch offset returns the stored word even while the gate is closed, and the kick offsets and every other offset return zero.
- R10: Writes to addresses other than the two kick offsets leave the key sequence unchanged, so a scratch write between the first and second key does not prevent opening.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| dn_we | output | 1 | Qualified write enable for downstream registers |

## Verification
The lock state is visible only through dn_we and through whether scratch writes stick. A sequencer stuck open shows up at once, because a protected write made just after a wrong or zero kick raises dn_we in that same cycle. A sequencer that skips the armed step shows up when a lone second key already lets a control write through. The scratch read-back after each attempted write makes a dropped or leaked store visible on the next read cycle. Reads of the kick offsets show whether any key value leaks back onto the bus.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_SCR   = 3,
    parameter int SCR_BASE  = 'h60,
    parameter int KICK0_OFS = 'h6C,
    parameter int KICK1_OFS = 'h70,
    parameter int TIME_BASE = 'h00,
    parameter int TIME_CNT  = 7,
    parameter int CTRL_OFS  = 'h40,
    parameter int STAT_OFS  = 'h44,
    parameter int IRQ_OFS   = 'h48,
    parameter int OSC_OFS   = 'h54,
    localparam int IDX_W    = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              kick0_hit,
    output logic              kick1_hit,
    output logic              scr_hit,
    output logic [IDX_W-1:0]  scr_idx,
    output logic              prot_hit,
    output logic              stat_hit
);

    logic [NUM_SCR-1:0]  scr_match;
    logic [TIME_CNT-1:0] time_match;

    // One comparator per scratch word
    for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
        assign scr_match[g] = (addr == ADDR_W'(SCR_BASE + 4 * g));
    end

    // One comparator per time-keeping word
    for (genvar t = 0; t < TIME_CNT; t++) begin : g_time
        assign time_match[t] = (addr == ADDR_W'(TIME_BASE + 4 * t));
    end

    always_comb begin
        scr_idx = '0;
        for (int i = 0; i < NUM_SCR; i++) begin
            if (scr_match[i]) scr_idx = IDX_W'(i);
        end
    end

    assign kick0_hit = (addr == ADDR_W'(KICK0_OFS));
    assign kick1_hit = (addr == ADDR_W'(KICK1_OFS));
    assign scr_hit   = |scr_match;
    assign stat_hit  = (addr == ADDR_W'(STAT_OFS));
    assign prot_hit  = (|time_match)
                     | (addr == ADDR_W'(CTRL_OFS))
                     | (addr == ADDR_W'(IRQ_OFS))
                     | (addr == ADDR_W'(OSC_OFS));

endmodule

// File: rtl/wp_key_seq.sv
module wp_key_seq
    import wp_gate_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY0   = 32'h83E7_0B13,
    parameter logic [31:0] KEY1   = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick0_wr,
    input  logic              kick1_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              gate_open
);

    localparam logic [DATA_W-1:0] K0 = DATA_W'(KEY0);
    localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY1);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (kick0_wr) begin
            seq_d.state = (wdata == K0) ? GATE_ARMED : GATE_LOCKED;
        end else if (kick1_wr) begin
            if (wdata != K1)
                seq_d.state = GATE_LOCKED;
            else if (seq_q.state == GATE_ARMED || seq_q.state == GATE_OPEN)
                seq_d.state = GATE_OPEN;
            else
                seq_d.state = GATE_LOCKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: GATE_LOCKED};
        else        seq_q <= seq_d;
    end

    assign gate_open = (seq_q.state == GATE_OPEN);

    // The gate opens only after a correct second key with the first key in place
    assert_open_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> ($past(kick1_wr) && $past(wdata) == K1
                              && $past(seq_q.state) == GATE_ARMED));

    // A lone second key from the locked state keeps the gate closed
    assert_lone_second_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick1_wr && seq_q.state == GATE_LOCKED) |=> !gate_open);

    // Any wrong kick value closes the gate on the next edge
    assert_bad_kick_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((kick0_wr && wdata != K0) || (kick1_wr && wdata != K1)) |=> !gate_open);

    // Non-kick cycles leave the sequence untouched
    assert_other_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!kick0_wr && !kick1_wr) |=> $stable(seq_q.state));

endmodule

// File: rtl/wp_scratch_bank.sv
module wp_scratch_bank #(
    parameter int DATA_W  = 32,
    parameter int NUM_SCR = 3,
    localparam int IDX_W  = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [NUM_SCR-1:0][DATA_W-1:0] words;
    } bank_regs_t;

    bank_regs_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_SCR; i++) begin
            if (wr_en && idx == IDX_W'(i)) bank_d.words[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SCR; i++) begin
            if (idx == IDX_W'(i)) rd_data = bank_q.words[i];
        end
    end

    // A word changes only on a qualified write aimed at it
    for (genvar g = 0; g < NUM_SCR; g++) begin : g_hold
        assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && idx == IDX_W'(g)) |=> $stable(bank_q.words[g]));
    end

endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          NUM_SCR   = 3,
    parameter int          SCR_BASE  = 'h60,
    parameter int          KICK0_OFS = 'h6C,
    parameter int          KICK1_OFS = 'h70,
    parameter int          TIME_BASE = 'h00,
    parameter int          TIME_CNT  = 7,
    parameter int          CTRL_OFS  = 'h40,
    parameter int          STAT_OFS  = 'h44,
    parameter int          IRQ_OFS   = 'h48,
    parameter int          OSC_OFS   = 'h54,
    parameter logic [31:0] KEY0      = 32'h83E7_0B13,
    parameter logic [31:0] KEY1      = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dn_we
);

    localparam int IDX_W = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;

    logic             kick0_hit, kick1_hit, scr_hit, prot_hit, stat_hit;
    logic [IDX_W-1:0] scr_idx;
    logic             gate_open;
    logic [DATA_W-1:0] scr_rd;

    wp_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_SCR(NUM_SCR), .SCR_BASE(SCR_BASE),
        .KICK0_OFS(KICK0_OFS), .KICK1_OFS(KICK1_OFS),
        .TIME_BASE(TIME_BASE), .TIME_CNT(TIME_CNT),
        .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
        .IRQ_OFS(IRQ_OFS), .OSC_OFS(OSC_OFS)
    ) u_decode (
        .addr(bus_addr),
        .kick0_hit(kick0_hit),
        .kick1_hit(kick1_hit),
        .scr_hit(scr_hit),
        .scr_idx(scr_idx),
        .prot_hit(prot_hit),
        .stat_hit(stat_hit)
    );

    wp_key_seq #(
        .DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .kick0_wr(bus_we && kick0_hit),
        .kick1_wr(bus_we && kick1_hit),
        .wdata(bus_wdata),
        .gate_open(gate_open)
    );

    wp_scratch_bank #(
        .DATA_W(DATA_W), .NUM_SCR(NUM_SCR)
    ) u_bank (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(bus_we && scr_hit && gate_open),
        .idx(scr_idx),
        .wdata(bus_wdata),
        .rd_data(scr_rd)
    );

    assign dn_we     = bus_we && ((prot_hit && gate_open) || stat_hit);
    assign bus_rdata = scr_hit ? scr_rd : '0;

    // Gate closed after reset
    assert_reset_closed_R1: assert property (@(posedge clk)
        !rst_n |=> !gate_open);

    // Closed gate: protected writes never reach downstream
    assert_locked_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && prot_hit && !gate_open) |-> !dn_we);

    // Open gate: protected writes pass
    assert_open_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && prot_hit && gate_open) |-> dn_we);

    // Status writes always pass
    assert_status_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && stat_hit) |-> dn_we);

    // Unmapped and kick offsets never reach downstream
    assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_hit && !stat_hit) |-> !dn_we);

    // Kick locations never expose their contents
    assert_kick_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kick0_hit || kick1_hit) |-> (bus_rdata == '0));

endmodule

// File: tb/wp_gate_bench.sv
module wp_gate_bench;

    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        dn_we;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    wp_gate u_wp_gate (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .dn_we(dn_we)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus write; returns dn_we seen during the write cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic seen);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        #2 seen = dn_we;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #2 d = bus_rdata;
    endtask

    task automatic unlock();
        logic s;
        wr(8'h6C, K0, s);
        wr(8'h70, K1, s);
    endtask

    task automatic relock();
        logic s;
        wr(8'h6C, 32'h0, s);
    endtask

    task automatic t_reset();
        logic s; logic [31:0] d;
        for (int i = 0; i < 3; i++) begin
            rd(8'(8'h60 + 4 * i), d);
            check("R1 scratch zero after reset", d, 32'h0);
        end
        wr(8'h40, 32'h1, s);
        check("R1 gate closed after reset", {31'b0, s}, 32'h0);
    endtask

    task automatic t_locked_drop();
        logic s; logic [31:0] d;
        wr(8'h60, 32'hAAAA_5555, s);
        rd(8'h60, d);
        check("R5 scratch write dropped while locked", d, 32'h0);
        wr(8'h08, 32'h12, s);
        check("R5 time write blocked", {31'b0, s}, 32'h0);
        wr(8'h54, 32'h40, s);
        check("R5 osc write blocked", {31'b0, s}, 32'h0);
    endtask

    task automatic t_status();
        logic s;
        wr(8'h44, 32'h40, s);
        check("R7 status write passes while locked", {31'b0, s}, 32'h1);
        unlock();
        wr(8'h44, 32'h80, s);
        check("R7 status write passes while open", {31'b0, s}, 32'h1);
        relock();
    endtask

    task automatic t_unmapped();
        logic s;
        wr(8'h20, 32'h1, s);
        check("R8 unmapped locked", {31'b0, s}, 32'h0);
        unlock();
        wr(8'h20, 32'h1, s);
        check("R8 unmapped open", {31'b0, s}, 32'h0);
        wr(8'h42, 32'h1, s);
        check("R8 misaligned open", {31'b0, s}, 32'h0);
        wr(8'h70, K1, s);
        check("R8 kick write no dn_we", {31'b0, s}, 32'h0);
        relock();
    endtask

    task automatic t_order();
        logic s;
        wr(8'h70, K1, s);
        wr(8'h40, 32'h1, s);
        check("R3 second key alone keeps closed", {31'b0, s}, 32'h0);
        wr(8'h6C, K0, s);
        wr(8'h40, 32'h1, s);
        check("R3 first key alone keeps closed", {31'b0, s}, 32'h0);
        wr(8'h70, K1, s);
        wr(8'h40, 32'h1, s);
        check("R2 open after key pair", {31'b0, s}, 32'h1);
        relock();
    endtask

    task automatic t_open();
        logic s; logic [31:0] d;
        unlock();
        wr(8'h00, 32'h59, s);
        check("R6 time base open", {31'b0, s}, 32'h1);
        wr(8'h18, 32'h6, s);
        check("R6 last time word open", {31'b0, s}, 32'h1);
        wr(8'h48, 32'h0, s);
        check("R6 irq open", {31'b0, s}, 32'h1);
        wr(8'h54, 32'h48, s);
        check("R6 osc open", {31'b0, s}, 32'h1);
        wr(8'h60, 32'hDEAD_BEEF, s);
        wr(8'h64, 32'h0123_4567, s);
        wr(8'h68, 32'hFFFF_0001, s);
        rd(8'h60, d); check("R6 scratch0 stored", d, 32'hDEAD_BEEF);
        rd(8'h64, d); check("R6 scratch1 stored", d, 32'h0123_4567);
        rd(8'h68, d); check("R6 scratch2 stored", d, 32'hFFFF_0001);
        rd(8'h6C, d); check("R9 kick0 reads zero", d, 32'h0);
        rd(8'h70, d); check("R9 kick1 reads zero", d, 32'h0);
        rd(8'h40, d); check("R9 other offset reads zero", d, 32'h0);
        relock();
        rd(8'h64, d); check("R9 scratch readable while locked", d, 32'h0123_4567);
    endtask

    task automatic t_relock();
        logic s; logic [31:0] d;
        unlock();
        wr(8'h70, 32'h0, s);
        wr(8'h40, 32'h1, s);
        check("R4 zero to kick1 locks", {31'b0, s}, 32'h0);
        wr(8'h60, 32'h1111_1111, s);
        rd(8'h60, d);
        check("R4 scratch dropped after relock", d, 32'hDEAD_BEEF);
        unlock();
        wr(8'h6C, 32'h1234_5678, s);
        wr(8'h40, 32'h1, s);
        check("R4 wrong value to kick0 locks", {31'b0, s}, 32'h0);
        unlock();
        wr(8'h70, K1 ^ 32'h1, s);
        wr(8'h0C, 32'h1, s);
        check("R4 near-miss key locks", {31'b0, s}, 32'h0);
        unlock();
        wr(8'h40, 32'h1, s);
        check("R2 reopen after relock", {31'b0, s}, 32'h1);
        relock();
    endtask

    task automatic t_interleave();
        logic s; logic [31:0] d;
        wr(8'h6C, K0, s);
        wr(8'h68, 32'h7777_7777, s);
        rd(8'h68, d);
        check("R10 scratch dropped while armed", d, 32'hFFFF_0001);
        wr(8'h40, 32'h1, s);
        wr(8'h70, K1, s);
        wr(8'h40, 32'h1, s);
        check("R10 unlock survives interleaved writes", {31'b0, s}, 32'h1);
        relock();
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        t_reset();
        t_locked_drop();
        t_status();
        t_unmapped();
        t_order();
        t_open();
        t_relock();
        t_interleave();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule